// File: doc/BRIEF.md
# Flash Line Fetcher

This block answers aligned 32-bit reads of a linear serial-flash window. It keeps one line of 256 words in a local buffer, tagged by the bus address that started its last fill. A read that falls inside the buffered line returns in the cycle after it is accepted, with no serial traffic. A read outside the line starts a fetch. The fetch selects one flash device and sends a read header byte by byte. It throws away what comes back during the header, collects 1024 data bytes into 256 words, and releases the device. The requested word is then returned from the start of the new line.

The header is built from a single 32-bit configuration word. The word holds the instruction code, an optional mode byte with its enable, a dummy byte count and a flag that marks two memories working side by side. When that flag is set, the bus address is halved before it goes to the flash. The byte transport below the block is a simple handshake. The block holds a byte on `xfer_tx` with `xfer_valid`, and the transport answers with a one-cycle `xfer_done` pulse carrying the received byte on `xfer_rx`.

Top module: `flash_line_fetcher`

## Requirements
- R1: After reset every chip select is high (inactive), no byte transfer is requested, `req_ready` is 1, `rsp_valid` is 0, the configuration word is 0x03A002EB and no line is valid, so the first read always fetches.
- R2: A fetch sends, in this order: the instruction code (config bits 7:0), then flash address bits 23:16, 15:8 and 7:0, then the mode byte (config bits 23:16) if config bit 25 is 1, then as many 0x00 bytes as config bits 10:8 give. With the reset configuration this is 0xEB, three address bytes, 0xA0, 0x00, 0x00.
- R3: Bytes received during the header never reach the buffer. Every byte sent during the data phase is 0x00.
- R4: Each group of four received data bytes forms one word. With `byte_order_msb_first` = 0 the first byte lands in bits 7:0 and the fourth in bits 31:24. With it at 1 the first byte lands in bits 31:24.
- R5: A read at address A is a hit when a line is valid, A >= base and A <= base + 1020. A hit makes no serial transfer and raises `rsp_valid` in the cycle after acceptance, with the word at offset A - base.
- R6: A read that is not a hit refills the whole line starting at flash address f(A). It then sets base to A and returns the first word of the new line.
- R7: When config bit 30 is 1, the flash address is A shifted right by one. When it is 0, the flash address is A.
- R8: The device index is flash-address bit 24. During a fetch, exactly that device's `cs_n` bit is low. All bits go high once the last data byte is taken, and no more than one bit is ever low.
- R9: `rsp_valid` stays high and `rsp_data` holds steady until `rsp_ready` is seen. `req_ready` is low while a fetch runs or a response is pending.
- R10: A one-cycle `cfg_we` loads `cfg_wdata` as the configuration word for later fetches. With config bit 25 clear, no mode byte is sent, and the dummy count alone sets the header length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Load strobe for the configuration word |
| cfg_wdata | input | 32 | New configuration word |
| byte_order_msb_first | input | 1 | 1: first received byte goes to bits 31:24 of a word |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 25 | Byte address in the flash window (aligned to 4) |
| rsp_valid | output | 1 | Read data present |
| rsp_ready | input | 1 | Consumer takes the read data |
| rsp_data | output | 32 | Read word |
| xfer_valid | output | 1 | Byte transfer requested |
| xfer_tx | output | 8 | Byte to send |
| xfer_done | input | 1 | One-cycle pulse: the current byte is finished |
| xfer_rx | input | 8 | Byte received, valid with `xfer_done` |
| cs_n | output | 2 | Active-low device selects, one per device |

## Verification
The hardest situations to reach from the ports lie at the edges of the hit window and around a reconfiguration. The stimulus places reads exactly at base + 1020, at base + 1024 and at base - 4. Only the first must be served without serial traffic. The other two move the line, and the later reads check that the move happened. The bench also rewrites the configuration so that the two-memory flag halves the address. It then reads a bus address whose bit 24 would pick device 1 without halving, and the expected select, header and data all require device 0 at the halved address. The flash model in the bench answers the header bytes with 0xEE, so any header byte that leaks into the buffer shows up as wrong data.

// File: rtl/lf_pkg.sv
// Shared types for the flash line fetcher.
// Assumes configuration fields sit at fixed bit positions that the header generator decodes.
package lf_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HDR,
        ST_DATA,
        ST_DONE
    } lf_state_e;

    typedef struct packed {
        logic       dual;
        logic       mode_en;
        logic [7:0] mode;
        logic [2:0] dummy;
        logic [7:0] instr;
    } lf_cfg_t;

    // Pull the header fields out of the raw configuration word.
    function automatic lf_cfg_t lf_decode(input logic [31:0] w);
        lf_cfg_t c;
        c.dual    = w[30];
        c.mode_en = w[25];
        c.mode    = w[23:16];
        c.dummy   = w[10:8];
        c.instr   = w[7:0];
        return c;
    endfunction

endpackage

// File: rtl/lf_hdr_gen.sv
// Header byte generator: given the byte index inside the read header, returns
// the byte to send and the index of the last header byte.
// Assumes the index never runs past last_idx (the caller stops there).
module lf_hdr_gen
    import lf_pkg::*;
(
    input  lf_cfg_t     cfg,
    input  logic [23:0] faddr,
    input  logic [3:0]  idx,
    output logic [7:0]  hdr_byte,
    output logic [3:0]  last_idx
);

    // Header length: instruction plus three address bytes, optional mode, dummies.
    assign last_idx = 4'd3 + {3'd0, cfg.mode_en} + {1'b0, cfg.dummy};

    // Select the byte for the current header position.
    always_comb begin
        case (idx)
            4'd0:    hdr_byte = cfg.instr;
            4'd1:    hdr_byte = faddr[23:16];
            4'd2:    hdr_byte = faddr[15:8];
            4'd3:    hdr_byte = faddr[7:0];
            4'd4:    hdr_byte = cfg.mode_en ? cfg.mode : 8'h00;
            default: hdr_byte = 8'h00;
        endcase
    end

endmodule

// File: rtl/lf_packer.sv
// Byte-to-word packer: gathers four received bytes into one 32-bit word with
// a selectable lane order and flags the byte that completes the word.
// Assumes clr is pulsed before each new line so the lane counter starts at zero.
module lf_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr,
    input  logic        byte_en,
    input  logic [7:0]  byte_in,
    input  logic        msb_first,
    output logic [31:0] word_out,
    output logic        word_done
);

    logic [31:0] acc_q;
    logic [1:0]  pos_q;
    logic [1:0]  lane;

    // Lane for this byte: count up from the low end, or down from the high end.
    assign lane      = msb_first ? ~pos_q : pos_q;
    assign word_out  = acc_q | ({24'd0, byte_in} << {lane, 3'b000});
    assign word_done = byte_en && (pos_q == 2'd3);

    // Accumulate bytes and restart after each finished word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_q <= '0;
            pos_q <= '0;
        end else if (byte_en) begin
            acc_q <= word_done ? 32'd0 : word_out;
            pos_q <= pos_q + 2'd1;
        end
    end

endmodule

// File: rtl/lf_line_mem.sv
// Line buffer: one write port for the fill, one combinational read port.
// Assumes reads and writes of the same word never need to bypass each other.
module lf_line_mem #(
    parameter int WORDS = 256,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [31:0]   wdata,
    input  logic [AW-1:0] raddr,
    output logic [31:0]   rdata
);

    logic [31:0] mem [WORDS];

    // Store a finished word during the fill.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/flash_line_fetcher.sv
// Flash line fetcher: serves aligned word reads from a one-line buffer and refills
// the line over a byte transfer handshake on a miss.
// Assumes requests are 4-byte aligned and the byte transport pulses xfer_done
// once per byte while xfer_valid is held.
module flash_line_fetcher
    import lf_pkg::*;
#(
    parameter int          LINE_WORDS = 256,
    parameter int          NUM_DEV    = 2,
    parameter int          DEV_LSB    = 24,
    parameter logic [31:0] CFG_RESET  = 32'h03A0_02EB,
    localparam int         DEV_W      = $clog2(NUM_DEV),
    localparam int         ADDR_W     = DEV_LSB + DEV_W,
    localparam int         WIDX_W     = $clog2(LINE_WORDS),
    localparam int         HIT_SPAN   = LINE_WORDS * 4 - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [31:0]       cfg_wdata,
    input  logic              byte_order_msb_first,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [31:0]       rsp_data,
    output logic              xfer_valid,
    output logic [7:0]        xfer_tx,
    input  logic              xfer_done,
    input  logic [7:0]        xfer_rx,
    output logic [NUM_DEV-1:0] cs_n
);

    lf_state_e          state;
    logic [31:0]        cfg_q;
    lf_cfg_t            cfg;
    logic [ADDR_W-1:0]  base_q, addr_q, offset, req_faddr;
    logic [23:0]        faddr_q;
    logic               line_ok;
    logic [3:0]         idx_q, last_idx;
    logic [7:0]         hdr_byte;
    logic [WIDX_W-1:0]  widx_q, raddr;
    logic [NUM_DEV-1:0] cs_n_q, cs_pick_n;
    logic [DEV_W-1:0]   req_dev;
    logic               rsp_valid_q, accept, hit, word_done;
    logic [31:0]        rsp_data_q, rd_word, packed_word;

    assign cfg       = lf_decode(cfg_q);
    assign req_faddr = cfg.dual ? (req_addr >> 1) : req_addr;
    assign req_dev   = req_faddr[DEV_LSB +: DEV_W];
    assign offset    = req_addr - base_q;
    assign hit       = line_ok && (req_addr >= base_q) && (offset <= ADDR_W'(HIT_SPAN));
    assign req_ready = (state == ST_IDLE) && !rsp_valid_q;
    assign accept    = req_valid && req_ready;
    assign raddr     = (state == ST_DONE) ? '0 : offset[WIDX_W+1:2];

    assign xfer_valid = (state == ST_HDR) || (state == ST_DATA);
    assign xfer_tx    = (state == ST_HDR) ? hdr_byte : 8'h00;
    assign rsp_valid  = rsp_valid_q;
    assign rsp_data   = rsp_data_q;
    assign cs_n       = cs_n_q;

    // One active-low select per device, low only for the addressed one.
    for (genvar d = 0; d < NUM_DEV; d++) begin : g_sel
        assign cs_pick_n[d] = (req_dev != DEV_W'(d));
    end

    lf_hdr_gen u_hdr (
        .cfg      (cfg),
        .faddr    (faddr_q),
        .idx      (idx_q),
        .hdr_byte (hdr_byte),
        .last_idx (last_idx)
    );

    lf_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (accept),
        .byte_en   ((state == ST_DATA) && xfer_done),
        .byte_in   (xfer_rx),
        .msb_first (byte_order_msb_first),
        .word_out  (packed_word),
        .word_done (word_done)
    );

    lf_line_mem #(.WORDS(LINE_WORDS)) u_mem (
        .clk   (clk),
        .we    (word_done),
        .waddr (widx_q),
        .wdata (packed_word),
        .raddr (raddr),
        .rdata (rd_word)
    );

    // Configuration word: reset value, then loaded by the write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    // Request handling, header and fill sequencing, response holding.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            line_ok     <= 1'b0;
            base_q      <= '0;
            addr_q      <= '0;
            faddr_q     <= '0;
            idx_q       <= '0;
            widx_q      <= '0;
            cs_n_q      <= '1;
            rsp_valid_q <= 1'b0;
            rsp_data_q  <= '0;
        end else begin
            if (rsp_valid_q && rsp_ready) begin
                rsp_valid_q <= 1'b0;
            end
            case (state)
                ST_IDLE: begin
                    if (accept && hit) begin
                        rsp_valid_q <= 1'b1;
                        rsp_data_q  <= rd_word;
                    end else if (accept) begin
                        addr_q  <= req_addr;
                        faddr_q <= req_faddr[23:0];
                        cs_n_q  <= cs_pick_n;
                        idx_q   <= '0;
                        state   <= ST_HDR;
                    end
                end
                ST_HDR: begin
                    if (xfer_done && (idx_q == last_idx)) begin
                        widx_q <= '0;
                        state  <= ST_DATA;
                    end else if (xfer_done) begin
                        idx_q <= idx_q + 4'd1;
                    end
                end
                ST_DATA: begin
                    if (word_done) begin
                        widx_q <= widx_q + 1'b1;
                        if (widx_q == WIDX_W'(LINE_WORDS - 1)) begin
                            cs_n_q  <= '1;
                            base_q  <= addr_q;
                            line_ok <= 1'b1;
                            state   <= ST_DONE;
                        end
                    end
                end
                ST_DONE: begin
                    rsp_valid_q <= 1'b1;
                    rsp_data_q  <= rd_word;
                    state       <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// Port-level checks for the flash line fetcher, bound into every instance.
// Assumes the reset is synchronous and active low.
module lf_checker #(
    parameter int NUM_DEV = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               rsp_valid,
    input logic               rsp_ready,
    input logic [31:0]        rsp_data,
    input logic               xfer_valid,
    input logic [NUM_DEV-1:0] cs_n
);

    // R8: never more than one device selected.
    p_single_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~cs_n) <= 1);

    // R8: a byte transfer always runs against a selected device.
    p_select_in_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_valid |-> !(&cs_n));

    // R8: while waiting for a request every device is released.
    p_release_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (&cs_n));

    // R9: an unaccepted response keeps its valid and its data.
    p_rsp_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

    // R9: no new request while busy fetching or holding a response.
    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid || rsp_valid) |-> !req_ready);

endmodule

bind flash_line_fetcher lf_checker #(.NUM_DEV(NUM_DEV)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data),
    .xfer_valid (xfer_valid),
    .cs_n       (cs_n)
);

// File: tb/tb_flash_line_fetcher.sv
module tb_flash_line_fetcher;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        msb_first = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [24:0] req_addr = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [31:0] rsp_data;
    logic        xfer_valid;
    logic [7:0]  xfer_tx;
    logic        xfer_done = 1'b0;
    logic [7:0]  xfer_rx = '0;
    logic [1:0]  cs_n;

    always #5 clk = ~clk;

    flash_line_fetcher dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
        .byte_order_msb_first(msb_first),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
        .xfer_valid(xfer_valid), .xfer_tx(xfer_tx), .xfer_done(xfer_done),
        .xfer_rx(xfer_rx), .cs_n(cs_n)
    );

    int n_checks = 0;
    int n_errs = 0;
    bit finished = 0;

    // Bench view of configuration and of the buffered line.
    logic [31:0] t_cfg = 32'h03A0_02EB;
    logic [24:0] t_base;
    logic [23:0] t_f;
    logic        t_dev, t_big;

    // Flash model state.
    int          k = 0;
    int          total_bytes = 0;
    int          data_tx_bad = 0;
    logic [7:0]  tx_log [16];
    logic [1:0]  cs_seen = 2'b11;
    int          m_hlen = 7;
    logic [23:0] m_fstart = '0;
    logic        m_dev = 1'b0;

    function automatic logic [7:0] fbyte(input logic dev, input logic [23:0] a);
        return (a[7:0] + {a[14:8], 1'b0} + a[23:16]) ^ (dev ? 8'hC3 : 8'h00);
    endfunction

    function automatic logic [31:0] exp_word(input logic [24:0] a);
        logic [23:0] fa;
        logic [7:0]  b0, b1, b2, b3;
        fa = t_f + 24'(a - t_base);
        b0 = fbyte(t_dev, fa);
        b1 = fbyte(t_dev, fa + 24'd1);
        b2 = fbyte(t_dev, fa + 24'd2);
        b3 = fbyte(t_dev, fa + 24'd3);
        return t_big ? {b0, b1, b2, b3} : {b3, b2, b1, b0};
    endfunction

    // Byte transport and flash: answers each byte one cycle later; header gets 0xEE.
    always @(negedge clk) begin
        if (!rst_n) begin
            xfer_done = 1'b0;
            k = 0;
        end else begin
            if (&cs_n) k = 0;
            if (xfer_done) begin
                xfer_done = 1'b0;
            end else if (xfer_valid) begin
                if (k < 16) tx_log[k] = xfer_tx;
                cs_seen = cs_n;
                if (k >= m_hlen && xfer_tx != 8'h00) data_tx_bad++;
                xfer_rx = (k < m_hlen) ? 8'hEE : fbyte(m_dev, m_fstart + 24'(k - m_hlen));
                xfer_done = 1'b1;
                k++;
                total_bytes++;
            end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] w);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        t_cfg = w;
    endtask

    task automatic do_read(input logic [24:0] a, output logic [31:0] d,
                           output int lat, output int nbytes);
        int b0;
        b0 = total_bytes;
        @(negedge clk);
        req_addr = a;
        req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 5000) begin
            @(negedge clk);
            lat++;
        end
        d = rsp_data;
        nbytes = total_bytes - b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    // One read with expected hit or miss; checks data, header, selects.
    task automatic run_vec(input logic [24:0] a, input bit miss);
        logic [31:0] d;
        logic [24:0] f;
        logic [7:0]  eb;
        int lat, nb;
        if (miss) begin
            f = t_cfg[30] ? {1'b0, a[24:1]} : a;
            m_dev = f[24];
            m_fstart = f[23:0];
            m_hlen = 4 + int'(t_cfg[25]) + int'(t_cfg[10:8]);
        end
        do_read(a, d, lat, nb);
        chk("R6 response arrived", {31'd0, lat < 5000}, 32'd1);
        if (miss) begin
            chk("R6 miss makes serial traffic", {31'd0, nb > 0}, 32'd1);
            t_base = a;
            t_f = m_fstart;
            t_dev = m_dev;
            t_big = msb_first;
            for (int i = 0; i < m_hlen; i++) begin
                if (i == 0) eb = t_cfg[7:0];
                else if (i == 1) eb = m_fstart[23:16];
                else if (i == 2) eb = m_fstart[15:8];
                else if (i == 3) eb = m_fstart[7:0];
                else if (i == 4 && t_cfg[25]) eb = t_cfg[23:16];
                else eb = 8'h00;
                chk($sformatf("R2 R10 header byte %0d", i), {24'd0, tx_log[i]}, {24'd0, eb});
            end
            chk("R8 R7 select during fetch", {30'd0, cs_seen}, {30'd0, ~(2'b01 << m_dev)});
            chk("R8 selects released", {30'd0, cs_n}, 32'd3);
        end else begin
            chk("R5 hit makes no traffic", nb, 32'd0);
            chk("R5 hit latency", lat, 32'd0);
        end
        chk("R4 R5 R6 read data", d, exp_word(a));
    endtask

    // Table: bit 25 = expected miss, bits 24:0 = address (reset configuration).
    localparam logic [25:0] VECS [8] = '{
        {1'b1, 25'h000_0100},
        {1'b0, 25'h000_0104},
        {1'b0, 25'h000_04FC},
        {1'b1, 25'h000_0500},
        {1'b1, 25'h000_04FC},
        {1'b0, 25'h000_08F8},
        {1'b1, 25'h100_0040},
        {1'b0, 25'h100_0100}
    };

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_errs++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
            $finish;
        end
    end

    initial begin
        logic [31:0] hold;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state at the ports.
        chk("R1 cs_n high", {30'd0, cs_n}, 32'd3);
        chk("R1 req_ready", {31'd0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1 xfer_valid", {31'd0, xfer_valid}, 32'd0);

        // Vector walk: first entry proves the line starts invalid (R1).
        for (int v = 0; v < 8; v++) begin
            run_vec(VECS[v][24:0], VECS[v][25]);
        end

        // R9: hold the response with rsp_ready low.
        @(negedge clk);
        req_addr = 25'h100_0044;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        hold = rsp_data;
        repeat (3) @(negedge clk);
        chk("R9 rsp_valid held", {31'd0, rsp_valid}, 32'd1);
        chk("R9 rsp_data stable", rsp_data, hold);
        chk("R9 req_ready low while pending", {31'd0, req_ready}, 32'd0);
        chk("R9 held word", hold, exp_word(25'h100_0044));
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 rsp_valid drops", {31'd0, rsp_valid}, 32'd0);

        // R4: most significant byte first.
        msb_first = 1'b1;
        run_vec(25'h002_0000, 1'b1);
        run_vec(25'h002_0008, 1'b0);
        msb_first = 1'b0;

        // R7 R10: two-memory flag halves the address; no mode byte, one dummy.
        write_cfg(32'h4000_010B);
        run_vec(25'h100_0080, 1'b1);
        run_vec(25'h100_0084, 1'b0);

        // R10: mode byte enabled, no dummy bytes.
        write_cfg(32'h0255_000B);
        run_vec(25'h030_0000, 1'b1);

        // R3: every data-phase byte sent was zero.
        chk("R3 data phase sends zeros", data_tx_bad, 32'd0);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", n_checks, n_errs);
        $finish;
    end

endmodule